// File: doc/BRIEF.md
# Programmable Duty Square Wave Pulser

This block drives one output line with a square wave whose high phase and low phase have separately programmed lengths. Each length is a 16-bit count of time units. A prescaler divides the system clock into a one-cycle unit tick, and the division ratio is a parameter. At a 125 MHz clock the default ratio gives a 100 µs unit, so the period runs from 0.4 ms (both counts at their floor of 2) to about 13.1 s (both counts at 65535).

Each count arrives as two byte-wide halves, the upper byte and the lower byte. A control byte enables the pulser through its bit 0. When the pulser is disabled the line is low and all internal counting is cleared. When it is enabled the wave always begins with a full high phase. A count is read only at the boundary that starts its phase, so software can rewrite the values at any time without shortening or stretching the phase in progress.

Top module: `sqw_pulser`

## Requirements
- R1: After reset, and in any cycle whose preceding clock edge saw bit 0 of `ctrl` at 0, `wave_out` is low. Bits 7..1 of `ctrl` have no effect.
- R2: On the first clock edge that sees `ctrl[0]` at 1 while the pulser is idle, `wave_out` goes high and a high phase begins.
- R3: A high phase lasts H × TICK_DIV clock cycles, where H = {`hi_msb`, `hi_lsb`} and `hi_msb` is bits 15..8.
- R4: A low phase lasts L × TICK_DIV clock cycles, where L = {`lo_msb`, `lo_lsb`} and `lo_msb` is bits 15..8.
- R5: A count of 0 or 1 is treated as 2. Counts of 2 and above are used unchanged.
- R6: A count is captured at the boundary that starts its phase. A change made during a phase first affects the next phase of that kind.
- R7: Clearing `ctrl[0]` in the middle of a phase drives `wave_out` low on the next clock edge. A later enable restarts with a complete high phase, and no partial unit is carried over.
- R8: The unit tick recurs every TICK_DIV cycles while the pulser runs, so that one full period is (H + L) × TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 8 | Control byte; bit 0 enables the pulser |
| hi_msb | input | 8 | High-time count, upper byte |
| hi_lsb | input | 8 | High-time count, lower byte |
| lo_msb | input | 8 | Low-time count, upper byte |
| lo_lsb | input | 8 | Low-time count, lower byte |
| wave_out | output | 1 | Square-wave output |

## Verification
The bench builds the pulser with TICK_DIV set to 4, so each unit is four cycles. At that ratio every phase width, the clamp to 2, and a 256-unit high phase that exercises the upper byte can all be measured exactly, cycle by cycle. The same ratio lets the bench place changes to the counts and drops of the enable at known offsets inside a phase, which is how it checks boundary capture and restart from idle.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    localparam int unsigned SQW_UNIT_W = 16;
    localparam int unsigned SQW_BYTE_W = SQW_UNIT_W / 2;
    localparam int unsigned SQW_MIN_UNITS = 2;

    typedef logic [SQW_UNIT_W-1:0] sqw_units_t;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } sqw_phase_e;

    typedef struct packed {
        sqw_units_t hi;
        sqw_units_t lo;
    } sqw_timing_t;

    typedef struct packed {
        sqw_phase_e phase;
        sqw_units_t rem;
        logic       wave;
    } sqw_state_t;

    localparam sqw_state_t SQW_IDLE = '{phase: PH_OFF, rem: '0, wave: 1'b0};

    function automatic sqw_units_t sqw_clamp(input sqw_units_t v);
        if (v < sqw_units_t'(SQW_MIN_UNITS))
            return sqw_units_t'(SQW_MIN_UNITS);
        return v;
    endfunction

endpackage

// File: rtl/sqw_tick_gen.sv
module sqw_tick_gen #(
    parameter int unsigned TICK_DIV = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    // R8: a tick never repeats on the next cycle (TICK_DIV is at least 2)
    p_tick_gap_r8: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R8: the divider never leaves its range
    p_cnt_range_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R7: a stop clears any partial unit
    p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/sqw_phase_ctl.sv
module sqw_phase_ctl
    import sqw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        tick,
    input  sqw_timing_t timing,
    output logic        active,
    output logic        wave
);
    sqw_state_t st_q;
    sqw_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = SQW_IDLE;
        end else begin
            unique case (st_q.phase)
                PH_OFF: begin
                    st_d.phase = PH_HIGH;
                    st_d.rem   = sqw_clamp(timing.hi);
                    st_d.wave  = 1'b1;
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (st_q.rem <= sqw_units_t'(1)) begin
                            st_d.phase = PH_LOW;
                            st_d.rem   = sqw_clamp(timing.lo);
                            st_d.wave  = 1'b0;
                        end else begin
                            st_d.rem = st_q.rem - 1'b1;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (st_q.rem <= sqw_units_t'(1)) begin
                            st_d.phase = PH_HIGH;
                            st_d.rem   = sqw_clamp(timing.hi);
                            st_d.wave  = 1'b1;
                        end else begin
                            st_d.rem = st_q.rem - 1'b1;
                        end
                    end
                end
                default: st_d = SQW_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= SQW_IDLE;
        else
            st_q <= st_d;
    end

    assign active = (st_q.phase != PH_OFF);
    assign wave   = st_q.wave;

    // R1: disabled means a low line on the next cycle
    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !wave);

    // R2: enabling from idle starts a high phase
    p_start_high_r2: assert property (@(posedge clk) disable iff (rst)
        (enable && st_q.phase == PH_OFF) |=> (wave && st_q.phase == PH_HIGH));

    // R6: the line only moves on a unit tick while running
    p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && active && !tick) |=> $stable(wave));

    // R5: a running phase always has units left, because loads are clamped
    p_rem_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        active |-> (st_q.rem != '0));

endmodule

// File: rtl/sqw_pulser.sv
module sqw_pulser
    import sqw_pkg::*;
#(
    parameter int unsigned TICK_DIV = 12500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            ctrl,
    input  logic [SQW_BYTE_W-1:0] hi_msb,
    input  logic [SQW_BYTE_W-1:0] hi_lsb,
    input  logic [SQW_BYTE_W-1:0] lo_msb,
    input  logic [SQW_BYTE_W-1:0] lo_lsb,
    output logic                  wave_out
);
    sqw_timing_t timing;
    logic        enable;
    logic        active;
    logic        tick;

    assign enable    = ctrl[0];
    assign timing.hi = {hi_msb, hi_lsb};
    assign timing.lo = {lo_msb, lo_lsb};

    sqw_tick_gen #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (enable && active),
        .tick (tick)
    );

    sqw_phase_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .tick   (tick),
        .timing (timing),
        .active (active),
        .wave   (wave_out)
    );

    initial begin
        if (TICK_DIV < 2)
            $error("sqw_pulser: TICK_DIV must be at least 2");
    end

endmodule

// File: tb/sqw_pulser_test.sv
module sqw_pulser_test;
    localparam int D = 4;
    localparam int LIMIT = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ctrl = 8'h00;
    logic [7:0] hi_msb = 8'h00, hi_lsb = 8'h02, lo_msb = 8'h00, lo_lsb = 8'h02;
    logic       wave_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sqw_pulser #(.TICK_DIV(D)) uut (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .hi_msb(hi_msb), .hi_lsb(hi_lsb), .lo_msb(lo_msb), .lo_lsb(lo_lsb),
        .wave_out(wave_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_times(input logic [15:0] h, input logic [15:0] l);
        hi_msb = h[15:8]; hi_lsb = h[7:0];
        lo_msb = l[15:8]; lo_lsb = l[7:0];
    endtask

    // counts negedge samples at level lvl, starting at the current negedge
    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (wave_out == lvl && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic go_idle();
        ctrl = 8'h00;
        repeat (5) @(negedge clk);
    endtask

    // enable and return at the first negedge of the high phase
    task automatic start_run();
        ctrl = 8'h01;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset low", int'(wave_out), 0);
    endtask

    task automatic t_disabled();
        int highs = 0;
        set_times(16'd3, 16'd5);
        ctrl = 8'h00;
        repeat (40) begin @(negedge clk); if (wave_out) highs++; end
        chk("R1 disabled stays low", highs, 0);
        ctrl = 8'hFE;
        highs = 0;
        repeat (40) begin @(negedge clk); if (wave_out) highs++; end
        chk("R1 upper ctrl bits ignored", highs, 0);
        go_idle();
    endtask

    task automatic t_basic();
        int h, l, h2;
        set_times(16'd3, 16'd5);
        start_run();
        chk("R2 first cycle high", int'(wave_out), 1);
        count_level(1'b1, h);
        chk("R3 high width", h, 3 * D);
        count_level(1'b0, l);
        chk("R4 low width", l, 5 * D);
        count_level(1'b1, h2);
        chk("R8 period", h2 + l, 8 * D);
        go_idle();
    endtask

    task automatic t_clamp();
        int h, l;
        set_times(16'd0, 16'd1);
        start_run();
        count_level(1'b1, h);
        chk("R5 high 0 clamped", h, 2 * D);
        count_level(1'b0, l);
        chk("R5 low 1 clamped", l, 2 * D);
        go_idle();
        set_times(16'd1, 16'd0);
        start_run();
        count_level(1'b1, h);
        chk("R5 high 1 clamped", h, 2 * D);
        count_level(1'b0, l);
        chk("R5 low 0 clamped", l, 2 * D);
        go_idle();
    endtask

    task automatic t_update();
        int h, l, h2;
        set_times(16'd3, 16'd5);
        start_run();
        @(negedge clk);
        set_times(16'd6, 16'd2);
        count_level(1'b1, h);
        chk("R6 running high kept", h + 1, 3 * D);
        count_level(1'b0, l);
        chk("R6 new low used", l, 2 * D);
        count_level(1'b1, h2);
        chk("R6 new high used", h2, 6 * D);
        go_idle();
    endtask

    task automatic t_restart();
        int h;
        set_times(16'd4, 16'd4);
        start_run();
        repeat (6) @(negedge clk);
        ctrl = 8'h00;
        @(negedge clk);
        chk("R7 low after stop", int'(wave_out), 0);
        repeat (3) @(negedge clk);
        chk("R7 stays low", int'(wave_out), 0);
        start_run();
        count_level(1'b1, h);
        chk("R7 full high after restart", h, 4 * D);
        go_idle();
    endtask

    task automatic t_bytes();
        int h, l;
        set_times(16'h0100, 16'h0003);
        start_run();
        count_level(1'b1, h);
        chk("R3 upper byte high", h, 256 * D);
        count_level(1'b0, l);
        chk("R4 lower byte low", l, 3 * D);
        go_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_basic();
        t_clamp();
        t_update();
        t_restart();
        t_bytes();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..R8 run): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule